// File: doc/BRIEF.md
# Multi-Core Inter-Processor Interrupt Register Block

This block holds the inter-processor interrupt state for a small cluster of cores. Each core owns a 32-bit pending-status word, a 32-bit enable word, and a 32-byte mailbox. Each core reaches the block through its own register port. A port carries an 8-bit register offset, a 2-bit length code, a 64-bit write datum, a read/write flag and a valid strobe. The response (valid, error, read data) is registered and appears one clock after the request. Every access works on the window of the core that owns the port.

Any core can post an interrupt to any core by writing a packed word to the send register. The word names a target core and a vector number, and the vector's status bit is set in the target. A core acknowledges its own interrupts by writing ones to its clear register. Each core's interrupt line is driven by a two-state machine held in a register. In state `IRQ_IDLE` the core's status is all zeros and the line is low. In state `IRQ_PENDING` the line is high. The *raise* transition (`IRQ_IDLE` to `IRQ_PENDING`) happens when the next status is non-zero, which can only happen when a send lands on an empty status. The *drop* transition (`IRQ_PENDING` to `IRQ_IDLE`) happens when clears leave the next status at zero. Otherwise the machine *holds* its state.

Top module: `ipi_cluster`

## Requirements
- R1: Register offsets are status 0x00, enable 0x04, set 0x08, clear 0x0C, mailbox 0x20 to 0x3F, and send 0x40. Only writes are accepted at 0x40. Any other offset, and any read of 0x40, returns an error.
- R2: A write to the enable register stores bits 31:0 of the datum for the accessing core. A read returns that value zero-extended to 64 bits.
- R3: Length codes 0, 1, 2 and 3 select 1, 2, 4 and 8 bytes. A mailbox write stores the low bytes of the datum little-endian from byte (offset minus 0x20). A mailbox read returns those bytes zero-extended.
- R4: A mailbox access whose offset plus length exceeds 0x40 returns an error and changes nothing.
- R5: A write to status or to set returns an error and has no effect. A read of set or clear returns 0 without error.
- R6: A write to the send register sets status bit (1 << data[4:0]) in the core numbered by data[25:16]. Several sends to one target in the same cycle all land.
- R7: A send whose target number is not below the core count is dropped without error.
- R8: A write to the clear register clears, in the caller's own status, every bit written as one.
- R9: A core's interrupt line rises on the clock edge at which a send lands on its all-zero status. It falls on the edge at which clears leave its status at zero.
- R10: When a send and a clear hit the same status bit in one cycle, the bit ends up set.
- R11: An access whose offset is not a multiple of its byte length sets that core's sticky alignment flag. The access is otherwise carried out in full.
- R12: Every request receives a response on the next clock edge. Read data is zero on an error and on any write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NCORES | Request strobe, one per core port |
| req_write | input | NCORES | 1 = write, 0 = read, per port |
| req_off | input | NCORES*8 | Register offset per port |
| req_len | input | NCORES*2 | Length code per port (0:1, 1:2, 2:4, 3:8 bytes) |
| req_wdata | input | NCORES*64 | Write datum per port |
| rsp_valid | output | NCORES | Response strobe, one cycle after the request |
| rsp_err | output | NCORES | Error response per port |
| rsp_rdata | output | NCORES*64 | Read data per port |
| irq | output | NCORES | Registered interrupt line per core |
| align_warn | output | NCORES | Sticky misalignment flag per core |

## Verification
A send and a clear can land on the same core in the same cycle, because each core has its own port. The bench provokes this by driving a send to core 2 on port 0 and an all-ones clear on port 2 in one cycle. It judges the outcome by two observations: core 2's interrupt line must stay high, and a later status read must show only the sent bit. Two sends from different ports aimed at one core are also issued together, and both bits must appear in that core's status.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
    localparam int OFF_W      = 8;
    localparam int DATA_W     = 64;
    localparam int LEN_W      = 2;

    localparam logic [OFF_W-1:0] OFF_STATUS = 8'h00;
    localparam logic [OFF_W-1:0] OFF_ENABLE = 8'h04;
    localparam logic [OFF_W-1:0] OFF_SET    = 8'h08;
    localparam logic [OFF_W-1:0] OFF_CLEAR  = 8'h0C;
    localparam logic [OFF_W-1:0] OFF_MBOX   = 8'h20;
    localparam logic [OFF_W-1:0] OFF_SEND   = 8'h40;

    typedef enum logic [2:0] {
        K_STATUS,
        K_ENABLE,
        K_SET,
        K_CLEAR,
        K_MAIL,
        K_SEND,
        K_BAD
    } acc_kind_e;

    typedef enum logic {
        IRQ_IDLE,
        IRQ_PENDING
    } irq_state_e;

    function automatic logic [3:0] len_to_bytes(input logic [LEN_W-1:0] code);
        return 4'd1 << code;
    endfunction
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
    import ipi_pkg::*;
#(
    parameter int MBOX_BYTES = 32
) (
    input  logic             acc_write,
    input  logic [OFF_W-1:0] acc_off,
    input  logic [LEN_W-1:0] acc_len,
    output acc_kind_e        kind,
    output logic             bad,
    output logic             misaligned
);
    localparam logic [OFF_W:0] MBOX_END = (OFF_W+1)'(OFF_MBOX) + (OFF_W+1)'(MBOX_BYTES);

    logic [3:0]     nbytes;
    logic [OFF_W:0] end_pos;

    always_comb begin
        nbytes     = len_to_bytes(acc_len);
        end_pos    = {1'b0, acc_off} + (OFF_W+1)'(nbytes);
        misaligned = (acc_off[3:0] & (nbytes - 4'd1)) != 4'd0;
        kind       = K_BAD;
        bad        = 1'b0;
        case (acc_off)
            OFF_STATUS: begin kind = K_STATUS; bad = acc_write;  end
            OFF_ENABLE: begin kind = K_ENABLE;                    end
            OFF_SET:    begin kind = K_SET;    bad = acc_write;  end
            OFF_CLEAR:  begin kind = K_CLEAR;                     end
            OFF_SEND:   begin kind = K_SEND;   bad = !acc_write; end
            default: begin
                if (acc_off >= OFF_MBOX && end_pos <= MBOX_END) begin
                    kind = K_MAIL;
                end else begin
                    kind = K_BAD;
                    bad  = 1'b1;
                end
            end
        endcase
    end
endmodule

// File: rtl/ipi_core_slice.sv
module ipi_core_slice
    import ipi_pkg::*;
#(
    parameter int STATUS_W   = 32,
    parameter int MBOX_BYTES = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                acc_valid,
    input  logic                acc_write,
    input  acc_kind_e           acc_kind,
    input  logic                acc_bad,
    input  logic                acc_misaligned,
    input  logic [OFF_W-1:0]    acc_off,
    input  logic [LEN_W-1:0]    acc_len,
    input  logic [DATA_W-1:0]   acc_wdata,
    input  logic [STATUS_W-1:0] set_vec,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [DATA_W-1:0]   rsp_rdata,
    output logic                irq,
    output logic                align_warn
);
    localparam int IDX_W = $clog2(MBOX_BYTES);
    localparam int LANES = DATA_W / 8;

    logic [STATUS_W-1:0] status_q, status_nxt, clr_mask;
    logic [STATUS_W-1:0] enable_q;
    logic [7:0]          mbox_q [MBOX_BYTES];
    irq_state_e          irq_q, irq_nxt;
    logic [IDX_W-1:0]    mb_base;
    logic [3:0]          nbytes;
    logic [DATA_W-1:0]   mail_rd, rd_val;
    logic                do_write, ok;

    always_comb begin
        ok       = acc_valid && !acc_bad;
        do_write = ok && acc_write;
        nbytes   = len_to_bytes(acc_len);
        mb_base  = IDX_W'(acc_off - OFF_MBOX);
        clr_mask = (do_write && acc_kind == K_CLEAR) ? acc_wdata[STATUS_W-1:0] : '0;
        // a send's bit is ORed in after the clear, so it survives (R10)
        status_nxt = (status_q & ~clr_mask) | set_vec;
    end

    // mailbox read lanes
    always_comb begin
        mail_rd = '0;
        for (int b = 0; b < LANES; b++) begin
            if (4'(b) < nbytes) begin
                mail_rd[8*b +: 8] = mbox_q[IDX_W'(mb_base + IDX_W'(b))];
            end
        end
    end

    always_comb begin
        rd_val = '0;
        case (acc_kind)
            K_STATUS: rd_val = DATA_W'(status_q);
            K_ENABLE: rd_val = DATA_W'(enable_q);
            K_MAIL:   rd_val = mail_rd;
            default:  rd_val = '0;
        endcase
    end

    // interrupt state machine: next state
    always_comb begin
        irq_nxt = irq_q;
        unique case (irq_q)
            IRQ_IDLE:    if (status_nxt != '0) irq_nxt = IRQ_PENDING;
            IRQ_PENDING: if (status_nxt == '0) irq_nxt = IRQ_IDLE;
        endcase
    end

    // interrupt state machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_q <= IRQ_IDLE;
        else        irq_q <= irq_nxt;
    end

    // interrupt state machine: outputs
    always_comb irq = (irq_q == IRQ_PENDING);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_q   <= '0;
            enable_q   <= '0;
            align_warn <= 1'b0;
            rsp_valid  <= 1'b0;
            rsp_err    <= 1'b0;
            rsp_rdata  <= '0;
        end else begin
            status_q   <= status_nxt;
            align_warn <= align_warn | (acc_valid && acc_misaligned);
            if (do_write && acc_kind == K_ENABLE) enable_q <= acc_wdata[STATUS_W-1:0];
            rsp_valid  <= acc_valid;
            rsp_err    <= acc_valid && acc_bad;
            rsp_rdata  <= (ok && !acc_write) ? rd_val : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < MBOX_BYTES; i++) mbox_q[i] <= 8'h00;
        end else if (do_write && acc_kind == K_MAIL) begin
            for (int b = 0; b < LANES; b++) begin
                if (4'(b) < nbytes) mbox_q[IDX_W'(mb_base + IDX_W'(b))] <= acc_wdata[8*b +: 8];
            end
        end
    end

    assert_irq_tracks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (status_q != '0));
    assert_send_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_vec != '0) |=> ((status_q & $past(set_vec)) == $past(set_vec)));
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((clr_mask & ~set_vec) != '0) |=> ((status_q & $past(clr_mask & ~set_vec)) == '0));
    assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        align_warn |=> align_warn);
    assert_err_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_rdata == '0));
endmodule

// File: rtl/ipi_cluster.sv
module ipi_cluster
    import ipi_pkg::*;
#(
    parameter int NCORES     = 4,
    parameter int ID_W       = 10,
    parameter int ID_LSB     = 16,
    parameter int VEC_W      = 5,
    parameter int MBOX_BYTES = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCORES-1:0]        req_valid,
    input  logic [NCORES-1:0]        req_write,
    input  logic [NCORES*OFF_W-1:0]  req_off,
    input  logic [NCORES*LEN_W-1:0]  req_len,
    input  logic [NCORES*DATA_W-1:0] req_wdata,
    output logic [NCORES-1:0]        rsp_valid,
    output logic [NCORES-1:0]        rsp_err,
    output logic [NCORES*DATA_W-1:0] rsp_rdata,
    output logic [NCORES-1:0]        irq,
    output logic [NCORES-1:0]        align_warn
);
    localparam int STATUS_W = 1 << VEC_W;

    acc_kind_e           kind_w   [NCORES];
    logic [NCORES-1:0]   bad_w, mis_w, send_hit;
    logic [ID_W-1:0]     send_tgt [NCORES];
    logic [VEC_W-1:0]    send_vec [NCORES];
    logic [STATUS_W-1:0] set_vec  [NCORES];

    for (genvar p = 0; p < NCORES; p++) begin : g_port
        ipi_decode #(.MBOX_BYTES(MBOX_BYTES)) u_dec (
            .acc_write  (req_write[p]),
            .acc_off    (req_off[p*OFF_W +: OFF_W]),
            .acc_len    (req_len[p*LEN_W +: LEN_W]),
            .kind       (kind_w[p]),
            .bad        (bad_w[p]),
            .misaligned (mis_w[p])
        );

        assign send_hit[p] = req_valid[p] && req_write[p] && kind_w[p] == K_SEND;
        assign send_tgt[p] = req_wdata[p*DATA_W + ID_LSB +: ID_W];
        assign send_vec[p] = req_wdata[p*DATA_W +: VEC_W];

        ipi_core_slice #(.STATUS_W(STATUS_W), .MBOX_BYTES(MBOX_BYTES)) u_core (
            .clk            (clk),
            .rst_n          (rst_n),
            .acc_valid      (req_valid[p]),
            .acc_write      (req_write[p]),
            .acc_kind       (kind_w[p]),
            .acc_bad        (bad_w[p]),
            .acc_misaligned (mis_w[p]),
            .acc_off        (req_off[p*OFF_W +: OFF_W]),
            .acc_len        (req_len[p*LEN_W +: LEN_W]),
            .acc_wdata      (req_wdata[p*DATA_W +: DATA_W]),
            .set_vec        (set_vec[p]),
            .rsp_valid      (rsp_valid[p]),
            .rsp_err        (rsp_err[p]),
            .rsp_rdata      (rsp_rdata[p*DATA_W +: DATA_W]),
            .irq            (irq[p]),
            .align_warn     (align_warn[p])
        );
    end

    // route every send to its target; unmatched target numbers fall away (R7)
    always_comb begin
        for (int t = 0; t < NCORES; t++) begin
            set_vec[t] = '0;
            for (int p = 0; p < NCORES; p++) begin
                if (send_hit[p] && send_tgt[p] == ID_W'(t)) begin
                    set_vec[t] = set_vec[t] | (STATUS_W'(1) << send_vec[p]);
                end
            end
        end
    end

    assert_resp_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[0] |=> rsp_valid[0]);
endmodule

// File: tb/ipi_cluster_test.sv
`timescale 1ns/1ps
module ipi_cluster_test;
    localparam int N = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [N-1:0]    req_valid = '0, req_write = '0;
    logic [N*8-1:0]  req_off = '0;
    logic [N*2-1:0]  req_len = '0;
    logic [N*64-1:0] req_wdata = '0;
    logic [N-1:0]    rsp_valid, rsp_err, irq, align_warn;
    logic [N*64-1:0] rsp_rdata;

    int checks = 0, failures = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ipi_cluster #(.NCORES(N)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_off(req_off), .req_len(req_len), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .irq(irq), .align_warn(align_warn)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  core;
        logic        wr;
        logic [7:0]  off;
        logic [1:0]  len;
        logic [63:0] data;
        logic        err;
        logic [63:0] rdata;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t TBL [NV] = '{
        '{4'd2,  2'd0, 1'b1, 8'h04, 2'd2, 64'hA5A51234, 1'b0, 64'h0},              // R2
        '{4'd2,  2'd0, 1'b0, 8'h04, 2'd2, 64'h0, 1'b0, 64'hA5A51234},              // R2
        '{4'd3,  2'd1, 1'b1, 8'h20, 2'd3, 64'h1122334455667788, 1'b0, 64'h0},      // R3
        '{4'd3,  2'd1, 1'b0, 8'h24, 2'd2, 64'h0, 1'b0, 64'h11223344},              // R3
        '{4'd3,  2'd1, 1'b1, 8'h21, 2'd0, 64'hEE, 1'b0, 64'h0},                    // R3
        '{4'd3,  2'd1, 1'b0, 8'h20, 2'd3, 64'h0, 1'b0, 64'h112233445566EE88},      // R3
        '{4'd4,  2'd1, 1'b0, 8'h3C, 2'd3, 64'h0, 1'b1, 64'h0},                     // R4
        '{4'd5,  2'd2, 1'b1, 8'h00, 2'd2, 64'h1, 1'b1, 64'h0},                     // R5
        '{4'd5,  2'd2, 1'b1, 8'h08, 2'd2, 64'h1, 1'b1, 64'h0},                     // R5
        '{4'd5,  2'd2, 1'b0, 8'h08, 2'd2, 64'h0, 1'b0, 64'h0},                     // R5
        '{4'd5,  2'd2, 1'b0, 8'h0C, 2'd2, 64'h0, 1'b0, 64'h0},                     // R5
        '{4'd1,  2'd2, 1'b0, 8'h10, 2'd2, 64'h0, 1'b1, 64'h0},                     // R1
        '{4'd6,  2'd3, 1'b1, 8'h40, 2'd2, 64'h00020005, 1'b0, 64'h0},              // R6
        '{4'd6,  2'd2, 1'b0, 8'h00, 2'd2, 64'h0, 1'b0, 64'h20},                    // R6
        '{4'd6,  2'd3, 1'b1, 8'h40, 2'd2, 64'h0002001F, 1'b0, 64'h0},              // R6
        '{4'd6,  2'd2, 1'b0, 8'h00, 2'd2, 64'h0, 1'b0, 64'h80000020},              // R6
        '{4'd8,  2'd2, 1'b1, 8'h0C, 2'd2, 64'h20, 1'b0, 64'h0},                    // R8
        '{4'd8,  2'd2, 1'b0, 8'h00, 2'd2, 64'h0, 1'b0, 64'h80000000},              // R8
        '{4'd7,  2'd0, 1'b1, 8'h40, 2'd2, 64'h00090003, 1'b0, 64'h0},              // R7
        '{4'd7,  2'd0, 1'b0, 8'h00, 2'd2, 64'h0, 1'b0, 64'h0},                     // R7
        '{4'd1,  2'd1, 1'b0, 8'h40, 2'd2, 64'h0, 1'b1, 64'h0},                     // R1
        '{4'd3,  2'd3, 1'b1, 8'h3C, 2'd2, 64'hDEADBEEF, 1'b0, 64'h0},              // R3
        '{4'd3,  2'd3, 1'b0, 8'h38, 2'd3, 64'h0, 1'b0, 64'hDEADBEEF00000000},      // R3
        '{4'd2,  2'd3, 1'b0, 8'h04, 2'd2, 64'h0, 1'b0, 64'h0},                     // R2
        '{4'd12, 2'd1, 1'b1, 8'h2E, 2'd1, 64'hCAFE, 1'b0, 64'h0},                  // R12
        '{4'd3,  2'd1, 1'b0, 8'h2C, 2'd2, 64'h0, 1'b0, 64'hCAFE0000}               // R3
    };

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge with the response
    task automatic access(input int c, input logic wr, input logic [7:0] off, input logic [1:0] ln,
                          input logic [63:0] d, output logic [63:0] rd, output logic er, output logic vl);
        req_valid[c] = 1'b1;
        req_write[c] = wr;
        req_off[c*8 +: 8] = off;
        req_len[c*2 +: 2] = ln;
        req_wdata[c*64 +: 64] = d;
        @(negedge clk);
        rd = rsp_rdata[c*64 +: 64];
        er = rsp_err[c];
        vl = rsp_valid[c];
        req_valid = '0;
        req_write = '0;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 20000 && !done) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] rd;
        logic er, vl;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R9, R11, R12)
        check(irq == '0, "R9 reset irq", 64'(irq), 64'h0);
        check(align_warn == '0, "R11 reset align", 64'(align_warn), 64'h0);
        check(rsp_valid == '0, "R12 reset rsp_valid", 64'(rsp_valid), 64'h0);

        for (int i = 0; i < NV; i++) begin
            access(int'(TBL[i].core), TBL[i].wr, TBL[i].off, TBL[i].len, TBL[i].data, rd, er, vl);
            checks++;
            if (!vl || er !== TBL[i].err || rd !== TBL[i].rdata) begin
                failures++;
                $display("FAIL R%0d row %0d actual=err%0b/%h expected=err%0b/%h (valid %0b)",
                         TBL[i].req, i, er, rd, TBL[i].err, TBL[i].rdata, vl);
            end
        end

        // R7: dropped send touched no core; only core 2 still pending (R9)
        for (int c = 0; c < N; c++) begin
            access(c, 1'b0, 8'h00, 2'd2, 64'h0, rd, er, vl);
            check(rd == ((c == 2) ? 64'h80000000 : 64'h0), "R7 status after dropped send", rd,
                  (c == 2) ? 64'h80000000 : 64'h0);
        end
        check(irq == 4'b0100, "R9 irq held by pending core", 64'(irq), 64'h4);
        // R11: only the row at 0x3C with 8 bytes was misaligned (core 1)
        check(align_warn == 4'b0010, "R11 sticky flag after table", 64'(align_warn), 64'h2);

        // R9 fall: clearing the last bit drops the line
        access(2, 1'b1, 8'h0C, 2'd2, 64'h80000000, rd, er, vl);
        check(irq == 4'b0000, "R9 irq drops on empty status", 64'(irq), 64'h0);

        // R9 rise: send lands on empty status of core 1
        access(0, 1'b1, 8'h40, 2'd2, 64'h00010007, rd, er, vl);
        check(irq == 4'b0010, "R9 irq rises after send", 64'(irq), 64'h2);

        // R10: send to core 2 (vector 3) and all-ones clear by core 2 in one cycle
        req_valid = 4'b0101;
        req_write = 4'b0101;
        req_off[0 +: 8] = 8'h40; req_len[0 +: 2] = 2'd2; req_wdata[0 +: 64] = 64'h00020003;
        req_off[16 +: 8] = 8'h0C; req_len[4 +: 2] = 2'd2; req_wdata[128 +: 64] = 64'hFFFFFFFF;
        @(negedge clk);
        req_valid = '0; req_write = '0;
        check(irq[2] == 1'b1, "R10 irq stays with send winning", 64'(irq), 64'h6);
        access(2, 1'b0, 8'h00, 2'd2, 64'h0, rd, er, vl);
        check(rd == 64'h8, "R10 status after send and clear", rd, 64'h8);

        // R6: two sends to core 0 in one cycle from ports 1 and 3
        req_valid = 4'b1010;
        req_write = 4'b1010;
        req_off[8 +: 8] = 8'h40; req_len[2 +: 2] = 2'd2; req_wdata[64 +: 64] = 64'h00000001;
        req_off[24 +: 8] = 8'h40; req_len[6 +: 2] = 2'd2; req_wdata[192 +: 64] = 64'h00000002;
        @(negedge clk);
        req_valid = '0; req_write = '0;
        access(0, 1'b0, 8'h00, 2'd2, 64'h0, rd, er, vl);
        check(rd == 64'h6, "R6 concurrent sends both land", rd, 64'h6);

        // R11: misaligned 4-byte read at 0x3A is still served
        access(3, 1'b0, 8'h3A, 2'd2, 64'h0, rd, er, vl);
        check(rd == 64'hBEEF0000 && !er, "R11 misaligned read served", rd, 64'hBEEF0000);
        check(align_warn == 4'b1010, "R11 flag set on core 3", 64'(align_warn), 64'hA);

        // R4: rejected write leaves mailbox unchanged
        access(3, 1'b1, 8'h3E, 2'd2, 64'h12345678, rd, er, vl);
        check(er == 1'b1, "R4 write past end errors", 64'(er), 64'h1);
        access(3, 1'b0, 8'h3C, 2'd2, 64'h0, rd, er, vl);
        check(rd == 64'hDEADBEEF, "R4 mailbox untouched", rd, 64'hDEADBEEF);

        // R5: rejected status write leaves status unchanged
        access(0, 1'b1, 8'h00, 2'd2, 64'hFFFFFFFF, rd, er, vl);
        access(0, 1'b0, 8'h00, 2'd2, 64'h0, rd, er, vl);
        check(rd == 64'h6, "R5 status write ignored", rd, 64'h6);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule